// File: doc/BRIEF.md
# Multi-Write-Port RAM with Invalidation Table

This block is a RAM with several write ports and several read ports. Every port may be used in every clock cycle, and no port ever waits for another. All storage is built from memories that have one write port and one read port each. Every write port stores its data only in its own copies of the data array. A read port then has to learn which write port last stored the address it reads.

That knowledge sits in a small last-writer table, which is also kept in one-write/one-read memories rather than in flip-flops. Each write port owns one slice of the table. On a write, the port reads the other ports' slices at its address and stores a code that makes their claims stale. A reader combines all slices at its address to find the latest writer, and then selects that writer's data copy.

A parameter picks the table code. The binary code uses an XOR of ports' entries, with log2(NW) bits per port. The pairwise-flag code uses NW-1 bits per port, one flag for each other port. Reads have one cycle of latency from a registered output.

Top module: `mwr_ram`

## Requirements
- R1: A read address presented at a clock edge yields its data on `rData` after that edge. The read returns the value stored by the most recent write committed at an earlier edge. A write commits at the edge where its enable is high.
- R2: When a read and a write target the same address at the same edge, the read returns the contents from before that write.
- R3: When different write ports store to one address at different edges, every read port returns the value from the port that wrote last, whichever port that is.
- R4: With `ENC` = 0 (binary), each write port keeps a table entry of log2(NW) bits. It stores its own index XORed with the other ports' entries, and a reader XORs all entries to find the last writer.
- R5: With `ENC` = 1 (pairwise flags), each write port keeps one flag for each other port. For a pair i<j, equal flags mean i wrote last and unequal flags mean j wrote last. Read data is identical to the binary mode.
- R6: While `rst` is high, and on the edge where it is first sampled low, every `rData` lane reads zero.
- R7: A read port that keeps the same address, where no write hits that address, keeps the same `rData` value.
- R8: A write port whose enable is low changes nothing, whatever its address and data.
- R9: Two write ports enabled with equal addresses at the same edge is illegal, and the checker flags it.
- R10: All enabled write ports with distinct addresses commit in the same cycle, and each value is read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the read output registers |
| wEn | input | NW | Write enable, one bit per write port |
| wAddr | input | NW*AW | Write address per port |
| wData | input | NW*DW | Write data per port |
| rAddr | input | NR*AW | Read address per port |
| rData | output | NR*DW | Read data per port, one cycle after its address |

## Verification
The bench builds two copies of the block with NW=4, NR=3, DW=16 and AW=5. One copy uses the binary table and the other uses the pairwise-flag table, and both receive the same stimulus and are checked against one golden model. Four writers exercise every writer pair, and the 3-bit pairwise entries exercise every flag slot. The 32-word space, with a frequently used 8-word hot range, makes overwrites by different ports and same-cycle read/write overlaps common.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic {
    ENC_BIN  = 1'b0,
    ENC_PAIR = 1'b1
  } lvtEnc_e;

  // position of the flag that port w keeps about partner p
  function automatic int pairSlot(input int w, input int p);
    return (p < w) ? p : p - 1;
  endfunction

endpackage

// File: rtl/mwr_bank.sv
module mwr_bank #(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wEn,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rAddr,
  output logic [W-1:0]  rData
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wEn) mem[wAddr] <= wData;
  end

  always_ff @(posedge clk) begin
    if (rst) rData <= '0;
    else     rData <= mem[rAddr];
  end
endmodule

// File: rtl/mwr_lvt_ctrl.sv
module mwr_lvt_ctrl
  import mwr_pkg::*;
#(
  parameter int      NW  = 4,
  parameter int      NR  = 2,
  parameter int      AW  = 6,
  parameter lvtEnc_e ENC = ENC_BIN,
  localparam int     SW  = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NW-1:0]          wEn,
  input  logic [NW-1:0][AW-1:0]  wAddr,
  input  logic [NR-1:0][AW-1:0]  rAddr,
  output logic [NR-1:0][SW-1:0]  rdSel
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = (ENC == ENC_BIN) ? SW : NW - 1;

  // fbOut[v][w]: slice of port w, seen by port v at wAddr[v]
  logic [LW-1:0] fbOut  [NW][NW];
  logic [LW-1:0] newEnt [NW];
  logic [LW-1:0] rdEnt  [NR][NW];

  for (genvar w = 0; w < NW; w++) begin : g_own
    for (genvar v = 0; v < NW; v++) begin : g_peer
      if (v != w) begin : g_fb
        logic [LW-1:0] arr [DEPTH];
        always_ff @(posedge clk) begin
          if (wEn[w]) arr[wAddr[w]] <= newEnt[w];
        end
        assign fbOut[v][w] = arr[wAddr[v]];
      end else begin : g_self
        assign fbOut[v][w] = '0;
      end
    end
    for (genvar r = 0; r < NR; r++) begin : g_rd
      mwr_bank #(.W(LW), .AW(AW)) u_tbl (
        .clk   (clk),
        .rst   (rst),
        .wEn   (wEn[w]),
        .wAddr (wAddr[w]),
        .wData (newEnt[w]),
        .rAddr (rAddr[r]),
        .rData (rdEnt[r][w])
      );
    end
  end

  if (ENC == ENC_BIN) begin : g_bin
    always_comb begin
      for (int w = 0; w < NW; w++) begin
        logic [LW-1:0] acc;
        acc = LW'(w);
        for (int v = 0; v < NW; v++) begin
          if (v != w) acc = acc ^ fbOut[w][v];
        end
        newEnt[w] = acc;
      end
    end
    always_comb begin
      for (int r = 0; r < NR; r++) begin
        logic [LW-1:0] acc;
        acc = '0;
        for (int w = 0; w < NW; w++) acc = acc ^ rdEnt[r][w];
        rdSel[r] = acc;
      end
    end
  end else begin : g_pair
    always_comb begin
      for (int w = 0; w < NW; w++) begin
        logic [LW-1:0] e;
        e = '0;
        for (int p = 0; p < NW; p++) begin
          if (p != w) begin
            e[pairSlot(w, p)] = (w < p) ? fbOut[w][p][pairSlot(p, w)]
                                        : ~fbOut[w][p][pairSlot(p, w)];
          end
        end
        newEnt[w] = e;
      end
    end
    always_comb begin
      for (int r = 0; r < NR; r++) begin
        logic [SW-1:0] sel;
        sel = '0;
        for (int w = 0; w < NW; w++) begin
          logic win;
          win = 1'b1;
          for (int p = 0; p < NW; p++) begin
            if (p != w) begin
              if (w < p) win = win & (rdEnt[r][w][pairSlot(w, p)] == rdEnt[r][p][pairSlot(p, w)]);
              else       win = win & (rdEnt[r][w][pairSlot(w, p)] != rdEnt[r][p][pairSlot(p, w)]);
            end
          end
          if (win) sel = SW'(w);
        end
        rdSel[r] = sel;
      end
    end
  end
endmodule

// File: rtl/mwr_data_dp.sv
module mwr_data_dp #(
  parameter int  NW = 4,
  parameter int  NR = 2,
  parameter int  DW = 16,
  parameter int  AW = 6,
  localparam int SW = $clog2(NW)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         wEn,
  input  logic [NW-1:0][AW-1:0] wAddr,
  input  logic [NW-1:0][DW-1:0] wData,
  input  logic [NR-1:0][AW-1:0] rAddr,
  input  logic [NR-1:0][SW-1:0] rdSel,
  output logic [NR-1:0][DW-1:0] rData
);
  logic [DW-1:0] bankOut [NR][NW];

  for (genvar w = 0; w < NW; w++) begin : g_wr
    for (genvar r = 0; r < NR; r++) begin : g_rd
      mwr_bank #(.W(DW), .AW(AW)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wEn   (wEn[w]),
        .wAddr (wAddr[w]),
        .wData (wData[w]),
        .rAddr (rAddr[r]),
        .rData (bankOut[r][w])
      );
    end
  end

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rData[r] = '0;
      for (int w = 0; w < NW; w++) begin
        if (rdSel[r] == SW'(w)) rData[r] = bankOut[r][w];
      end
    end
  end
endmodule

// File: rtl/mwr_ram.sv
module mwr_ram
  import mwr_pkg::*;
#(
  parameter int      NW  = 4,
  parameter int      NR  = 3,
  parameter int      DW  = 16,
  parameter int      AW  = 6,
  parameter lvtEnc_e ENC = ENC_BIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         wEn,
  input  logic [NW-1:0][AW-1:0] wAddr,
  input  logic [NW-1:0][DW-1:0] wData,
  input  logic [NR-1:0][AW-1:0] rAddr,
  output logic [NR-1:0][DW-1:0] rData
);
  localparam int SW = $clog2(NW);

  logic [NR-1:0][SW-1:0] rdSel;

  mwr_lvt_ctrl #(.NW(NW), .NR(NR), .AW(AW), .ENC(ENC)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wEn   (wEn),
    .wAddr (wAddr),
    .rAddr (rAddr),
    .rdSel (rdSel)
  );

  mwr_data_dp #(.NW(NW), .NR(NR), .DW(DW), .AW(AW)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .wEn   (wEn),
    .wAddr (wAddr),
    .wData (wData),
    .rAddr (rAddr),
    .rdSel (rdSel),
    .rData (rData)
  );
endmodule

// File: rtl/mwr_ram_chk.sv
module mwr_ram_chk #(
  parameter int NW = 4,
  parameter int NR = 3,
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NW-1:0]         wEn,
  input logic [NW-1:0][AW-1:0] wAddr,
  input logic [NW-1:0][DW-1:0] wData,
  input logic [NR-1:0][AW-1:0] rAddr,
  input logic [NR-1:0][DW-1:0] rData
);
  logic [NR-1:0] hit;
  logic          rstQ = 1'b0;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      hit[r] = 1'b0;
      for (int w = 0; w < NW; w++) begin
        if (wEn[w] && wAddr[w] == rAddr[r]) hit[r] = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    // R6
    if (rstQ) rst_zero_chk: assert (rData == '0);
    rstQ <= rst;
  end

  for (genvar i = 0; i < NW; i++) begin : g_wi
    for (genvar j = i + 1; j < NW; j++) begin : g_wj
      // R9
      no_wcollide_chk: assert property (@(posedge clk) disable iff (rst)
        !(wEn[i] && wEn[j] && wAddr[i] == wAddr[j]));
    end
    for (genvar r = 0; r < NR; r++) begin : g_r
      // R1
      wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (wEn[i] ##1 (rAddr[r] == $past(wAddr[i]))) |=> (rData[r] == $past(wData[i], 2)));
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_hold
    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && rAddr[r] == $past(rAddr[r]) && !$past(hit[r])) |=> $stable(rData[r]));
  end
endmodule

bind mwr_ram mwr_ram_chk #(.NW(NW), .NR(NR), .DW(DW), .AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wEn   (wEn),
  .wAddr (wAddr),
  .wData (wData),
  .rAddr (rAddr),
  .rData (rData)
);

// File: tb/tb_mwr_ram.sv
`timescale 1ns/1ps
module tb_mwr_ram;
  import mwr_pkg::*;

  localparam int NW = 4, NR = 3, DW = 16, AW = 5, DEPTH = 1 << AW;
  localparam int NVEC = 6;
  // vector fields: {write mask[3:0], base address[4:0], read rotation[1:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {4'b0001, 5'd0,  2'd0},
    {4'b1111, 5'd4,  2'd1},
    {4'b1010, 5'd5,  2'd2},
    {4'b0110, 5'd3,  2'd3},
    {4'b1111, 5'd28, 2'd0},
    {4'b0101, 5'd4,  2'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NW-1:0]         wEn;
  logic [NW-1:0][AW-1:0] wAddr;
  logic [NW-1:0][DW-1:0] wData;
  logic [NR-1:0][AW-1:0] rAddr;
  logic [NR-1:0][DW-1:0] rDataB;
  logic [NR-1:0][DW-1:0] rDataT;

  mwr_ram #(.NW(NW), .NR(NR), .DW(DW), .AW(AW), .ENC(ENC_BIN)) dut (
    .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .wData(wData),
    .rAddr(rAddr), .rData(rDataB));

  mwr_ram #(.NW(NW), .NR(NR), .DW(DW), .AW(AW), .ENC(ENC_PAIR)) dutPair (
    .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .wData(wData),
    .rAddr(rAddr), .rData(rDataT));

  logic [DW-1:0] gm [DEPTH];
  logic          gv [DEPTH];
  int unsigned   nChk = 0, nErr = 0;
  logic          done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock with the inputs as they stand; reads compared against golden
  task automatic step(input string req);
    logic [DW-1:0] e  [NR];
    logic          ev [NR];
    for (int r = 0; r < NR; r++) begin
      e[r]  = gm[rAddr[r]];
      ev[r] = gv[rAddr[r]];
    end
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      if (ev[r]) begin
        chk({req, " R4 binary"}, rDataB[r], e[r]);
        chk({req, " R5 pairwise"}, rDataT[r], e[r]);
      end
    end
    for (int w = 0; w < NW; w++) begin
      if (wEn[w]) begin
        gm[wAddr[w]] = wData[w];
        gv[wAddr[w]] = 1'b1;
      end
    end
  endtask

  task automatic randStep();
    logic hot;
    hot = 1'($urandom_range(0, 1));
    for (int w = 0; w < NW; w++) begin
      logic          en;
      logic [AW-1:0] a;
      en = 1'($urandom_range(0, 1));
      a  = AW'(hot ? $urandom_range(0, 7) : $urandom_range(0, DEPTH - 1));
      for (int v = 0; v < w; v++) begin
        if (wEn[v] && wAddr[v] == a) en = 1'b0;
      end
      wEn[w]   = en;
      wAddr[w] = a;
      wData[w] = DW'($urandom);
    end
    for (int r = 0; r < NR; r++) begin
      if ($urandom_range(0, 1) == 1) rAddr[r] = wAddr[$urandom_range(0, NW - 1)];
      else                           rAddr[r] = AW'($urandom_range(0, DEPTH - 1));
    end
    step("R1 R3 R10 random");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      gm[a] = '0;
      gv[a] = 1'b0;
    end
    wEn   = '0;
    wAddr = '0;
    wData = '0;
    for (int r = 0; r < NR; r++) rAddr[r] = AW'(r * 5);

    // R6: outputs held at zero during reset
    repeat (3) begin
      @(negedge clk);
      for (int r = 0; r < NR; r++) begin
        chk("R6 binary", rDataB[r], '0);
        chk("R6 pairwise", rDataT[r], '0);
      end
    end
    rst = 1'b0;
    @(negedge clk);

    // vector table: parallel writes, then read-back
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]    mask;
      logic [AW-1:0] base;
      logic [1:0]    rot;
      {mask, base, rot} = VEC[i];
      for (int w = 0; w < NW; w++) begin
        wEn[w]   = mask[w];
        wAddr[w] = base + AW'(w);
        wData[w] = DW'(32'h1000 * (i + 1) + 32'h11 * w);
      end
      for (int r = 0; r < NR; r++) rAddr[r] = base + AW'((r + rot) % NW);
      step("R10 R2 vector write");
      wEn = '0;
      step("R1 R3 vector readback");
      for (int r = 0; r < NR; r++) rAddr[r] = base + AW'((r + rot + 1) % NW);
      step("R1 R10 vector readback");
    end

    // R2 / R3: overwrite by another port with a read in the same cycle
    wEn = '0;
    wEn[1] = 1'b1; wAddr[1] = 5'd9; wData[1] = 16'hAAAA;
    step("R3 first write");
    wEn = '0;
    wEn[2] = 1'b1; wAddr[2] = 5'd9; wData[2] = 16'hBBBB;
    rAddr[0] = 5'd9; rAddr[1] = 5'd9; rAddr[2] = 5'd9;
    step("R2 old data on same-cycle write");
    wEn = '0;
    step("R3 later port wins");
    wEn[0] = 1'b1; wAddr[0] = 5'd9; wData[0] = 16'hCCCC;
    wEn[3] = 1'b1; wAddr[3] = 5'd10; wData[3] = 16'hDDDD;
    step("R2 old data again");
    wEn = '0;
    rAddr[2] = 5'd10;
    step("R3 R10 port0 and port3");

    // R8: disabled ports with junk on address and data
    for (int w = 0; w < NW; w++) begin
      wAddr[w] = 5'd9;
      wData[w] = 16'hFFFF;
    end
    rAddr[0] = 5'd9; rAddr[1] = 5'd9; rAddr[2] = 5'd9;
    step("R8 disabled write");
    step("R8 disabled write after");
    // R7: steady address, no writes
    repeat (3) step("R7 hold");

    repeat (3000) randStep();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule